// File: doc/BRIEF.md
# GPIO Bank Register File

This block holds the control and status state for a group of general-purpose pins. The pins are split into ports of eight. Each port has its own set of registers on a simple synchronous register bus. Software uses these registers to claim a pin for GPIO use, to turn its output driver on or off, to set the level it drives, to read the level it receives, and to manage its interrupt state. Edge and level detection is done outside this block. An external detector reads the enable and type fields from this block's outputs and sends back one event pulse per pin, and this block latches those pulses as pending status.

Some registers have a second address that does a masked update. The upper byte of the write data selects which pins change, and the lower byte gives their new values. A driver can therefore change one pin with one store, even when other agents own the neighbouring pins. Pin inputs pass through a two-stage synchronizer before they reach the input register or the detector.

Top module: `pinbank_regfile`

## Requirements
- R1: After reset every register reads zero, and `pin_oe`, `pin_out`, `irq_en_o`, `irq_type_o` and `irq_stat_o` are all zero.
- R2: A plain write to byte address `fn*0x10 + port*4` loads that port's register, and a read at the same address returns it. The function codes are fn 0 config, 1 output enable, 2 output value, 5 interrupt enable and 6 interrupt type. Byte-wide registers keep bits [7:0], and bits above them read as zero. The type register keeps bits [23:0]. Bits [7:0] hold the level polarity, bits [15:8] the edge select and bits [23:16] the both-edges flag, one bit per pin. Enable and type are also visible on `irq_en_o` and `irq_type_o`, with pin p*8+n at bit p*8+n (and at bit p*24+f*8+n for field f of the type).
- R3: A write at the plain address plus 0x800 is masked. For each n, bit 8+n of the data selects pin n, and a selected pin takes the value of bit n. Unselected pins keep their value, and data bits [31:16] are ignored. For the type register only bits [7:0] can be changed this way. This alias exists for config, output enable, output, status, interrupt enable and type.
- R4: Reading fn 3 returns the port's pins after a two-flop synchronizer. A pin change made before clock edge k shows in the read data after edge k+2 and not earlier. `pin_level` shows the synchronized value after edge k+1.
- R5: A 1 on `evt_in[i]` for one cycle sets status bit i (fn 4). The bit stays set until it is cleared, and `irq_stat_o` mirrors it.
- R6: Writing fn 7 clears each status bit whose data bit is 1. Data bits that are 0 have no effect, and reads of fn 7 return zero.
- R7: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `pin_oe[i]` is 1 only when both the config bit and the output-enable bit of pin i are 1. `pin_out[i]` always carries the output-value bit.
- R9: Addresses that are not mapped read zero and ignore writes. These are: addresses with bits [1:0] not zero, addresses with bits [10:7] not zero, port indices at or above the port count, and the masked aliases of fn 3 and fn 7. Reads at any masked alias also return zero.
- R10: `bus_rdata` is registered. It shows the register selected by `bus_addr` one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | N_PORTS*PORT_W | Raw pin levels from the pads |
| pin_out | output | N_PORTS*PORT_W | Output values to the pads |
| pin_oe | output | N_PORTS*PORT_W | Per-pin driver enable |
| pin_level | output | N_PORTS*PORT_W | Synchronized pin levels for the detector |
| evt_in | input | N_PORTS*PORT_W | Per-pin event pulses from the detector |
| irq_en_o | output | N_PORTS*PORT_W | Interrupt enable bits |
| irq_type_o | output | N_PORTS*3*PORT_W | Interrupt type fields, 24 bits per port |
| irq_stat_o | output | N_PORTS*PORT_W | Pending status bits |

## Verification
The bench builds the block with its default values: four ports of eight pins. This keeps the whole address map small enough to visit every port at every function code, including each unmapped variant. The masked alias is driven with many select and value patterns on several ports, and the expected result is computed as a bitwise merge. Synchronizer latency is checked edge by edge. Event/clear ordering is checked on single bits inside a port whose other bits are cleared in the same write.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
package pinbank_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    FN_CFG   = 3'd0,
    FN_OE    = 3'd1,
    FN_OUT   = 3'd2,
    FN_IN    = 3'd3,
    FN_STAT  = 3'd4,
    FN_IEN   = 3'd5,
    FN_ITYPE = 3'd6,
    FN_ICLR  = 3'd7
  } fn_e;

  typedef struct packed {
    logic       hit;
    logic       masked;
    fn_e        fn;
    logic [1:0] port;
  } dec_t;
endpackage

// File: rtl/pinbank_sync.sv
`timescale 1ns/1ps
module pinbank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pinbank_decode.sv
`timescale 1ns/1ps
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  logic aligned, bank_ok, port_ok, alias_ok;
  fn_e  fn;

  always_comb begin
    fn       = fn_e'(addr[6:4]);
    aligned  = (addr[1:0] == 2'b00);
    bank_ok  = (addr[10:7] == 4'h0);
    port_ok  = (32'(addr[3:2]) < N_PORTS);
    alias_ok = !addr[11] || !((fn == FN_IN) || (fn == FN_ICLR));
    dec.hit    = aligned && bank_ok && port_ok && alias_ok;
    dec.masked = addr[11];
    dec.fn     = fn;
    dec.port   = addr[3:2];
  end
endmodule

// File: rtl/pinbank_port.sv
`timescale 1ns/1ps
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int TYPE_W = 3 * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              masked,
  input  fn_e               fn,
  input  logic [TYPE_W-1:0] wdata,
  input  logic [PORT_W-1:0] evt,
  output logic [PORT_W-1:0] cfg_q,
  output logic [PORT_W-1:0] oe_q,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] ien_q,
  output logic [PORT_W-1:0] stat_q,
  output logic [TYPE_W-1:0] type_q
);
  logic [PORT_W-1:0] wr_val, wr_msk;
  logic [PORT_W-1:0] cfg_d, oe_d, out_d, ien_d, stat_d;
  logic [TYPE_W-1:0] type_d;
  logic cfg_en, oe_en, out_en, ien_en, type_en, stat_en;
  logic stat_wr, stat_clr;

  always_comb begin
    wr_val   = wdata[PORT_W-1:0];
    wr_msk   = masked ? wdata[2*PORT_W-1:PORT_W] : '1;
    cfg_en   = wr && (fn == FN_CFG);
    oe_en    = wr && (fn == FN_OE);
    out_en   = wr && (fn == FN_OUT);
    ien_en   = wr && (fn == FN_IEN);
    type_en  = wr && (fn == FN_ITYPE);
    stat_wr  = wr && (fn == FN_STAT);
    stat_clr = wr && (fn == FN_ICLR);
    stat_en  = stat_wr || stat_clr || (|evt);

    cfg_d = (cfg_q & ~wr_msk) | (wr_val & wr_msk);
    oe_d  = (oe_q  & ~wr_msk) | (wr_val & wr_msk);
    out_d = (out_q & ~wr_msk) | (wr_val & wr_msk);
    ien_d = (ien_q & ~wr_msk) | (wr_val & wr_msk);
    if (masked)
      type_d = {type_q[TYPE_W-1:PORT_W],
                (type_q[PORT_W-1:0] & ~wr_msk) | (wr_val & wr_msk)};
    else
      type_d = wdata;

    stat_d = stat_q;
    if (stat_wr)  stat_d = (stat_q & ~wr_msk) | (wr_val & wr_msk);
    if (stat_clr) stat_d = stat_d & ~wr_val;
    stat_d = stat_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= '0;
    else if (oe_en) oe_q <= oe_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else if (ien_en) ien_q <= ien_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) type_q <= '0;
    else if (type_en) type_q <= type_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/pinbank_regfile.sv
`timescale 1ns/1ps
module pinbank_regfile
  import pinbank_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int PORT_W  = 8,
  localparam int N_PINS = N_PORTS * PORT_W,
  localparam int TYPE_W = 3 * PORT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [BUS_W-1:0]          bus_wdata,
  output logic [BUS_W-1:0]          bus_rdata,
  input  logic [N_PINS-1:0]         pin_in,
  output logic [N_PINS-1:0]         pin_out,
  output logic [N_PINS-1:0]         pin_oe,
  output logic [N_PINS-1:0]         pin_level,
  input  logic [N_PINS-1:0]         evt_in,
  output logic [N_PINS-1:0]         irq_en_o,
  output logic [N_PORTS*TYPE_W-1:0] irq_type_o,
  output logic [N_PINS-1:0]         irq_stat_o
);
  logic rst_meta_q, rst_sync_n;
  dec_t dec;
  logic [BUS_W-1:0] rdata_d, rdata_q;

  logic [PORT_W-1:0] cfg_a  [N_PORTS];
  logic [PORT_W-1:0] oe_a   [N_PORTS];
  logic [PORT_W-1:0] out_a  [N_PORTS];
  logic [PORT_W-1:0] ien_a  [N_PORTS];
  logic [PORT_W-1:0] stat_a [N_PORTS];
  logic [PORT_W-1:0] lvl_a  [N_PORTS];
  logic [TYPE_W-1:0] type_a [N_PORTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pinbank_decode #(.N_PORTS(N_PORTS)) u_dec (.addr(bus_addr), .dec(dec));

  pinbank_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pin_in), .q(pin_level)
  );

  generate
    if (BUS_W > TYPE_W) begin : g_spare
      logic wdata_unused;
      assign wdata_unused = ^bus_wdata[BUS_W-1:TYPE_W];
    end
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic wr_p;
      assign wr_p = bus_we && dec.hit && (32'(dec.port) == p);

      pinbank_port #(.PORT_W(PORT_W)) u_port (
        .clk(clk), .rst_n(rst_sync_n),
        .wr(wr_p), .masked(dec.masked), .fn(dec.fn),
        .wdata(bus_wdata[TYPE_W-1:0]),
        .evt(evt_in[p*PORT_W +: PORT_W]),
        .cfg_q(cfg_a[p]), .oe_q(oe_a[p]), .out_q(out_a[p]),
        .ien_q(ien_a[p]), .stat_q(stat_a[p]), .type_q(type_a[p])
      );

      assign lvl_a[p]                        = pin_level[p*PORT_W +: PORT_W];
      assign pin_out[p*PORT_W +: PORT_W]     = out_a[p];
      assign pin_oe[p*PORT_W +: PORT_W]      = cfg_a[p] & oe_a[p];
      assign irq_en_o[p*PORT_W +: PORT_W]    = ien_a[p];
      assign irq_stat_o[p*PORT_W +: PORT_W]  = stat_a[p];
      assign irq_type_o[p*TYPE_W +: TYPE_W]  = type_a[p];
    end
  endgenerate

  always_comb begin
    rdata_d = '0;
    if (dec.hit && !dec.masked) begin
      case (dec.fn)
        FN_CFG:   rdata_d = BUS_W'(cfg_a[dec.port]);
        FN_OE:    rdata_d = BUS_W'(oe_a[dec.port]);
        FN_OUT:   rdata_d = BUS_W'(out_a[dec.port]);
        FN_IN:    rdata_d = BUS_W'(lvl_a[dec.port]);
        FN_STAT:  rdata_d = BUS_W'(stat_a[dec.port]);
        FN_IEN:   rdata_d = BUS_W'(ien_a[dec.port]);
        FN_ITYPE: rdata_d = BUS_W'(type_a[dec.port]);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pinbank_chk.sv
`timescale 1ns/1ps
module pinbank_chk #(
  parameter int N_PINS = 32,
  parameter int TYPE_BITS = 96
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [11:0]          bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_rdata,
  input logic [N_PINS-1:0]    evt_in,
  input logic [N_PINS-1:0]    pin_oe,
  input logic [N_PINS-1:0]    pin_out,
  input logic [N_PINS-1:0]    irq_en_o,
  input logic [TYPE_BITS-1:0] irq_type_o,
  input logic [N_PINS-1:0]    irq_stat_o
);
  logic unmapped, stat_touch, clr_addr;
  assign unmapped   = (bus_addr[1:0] != 2'b00) || (bus_addr[10:7] != 4'h0);
  assign clr_addr   = (bus_addr[6:4] == 3'd7);
  assign stat_touch = bus_we && ((bus_addr[6:4] == 3'd4) || clr_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (pin_oe == '0 && pin_out == '0 && irq_stat_o == '0
                                && irq_en_o == '0 && bus_rdata == '0);
    end
  end

  a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_touch |=> ((irq_stat_o & $past(irq_stat_o)) == $past(irq_stat_o)));

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((irq_stat_o & $past(evt_in)) == $past(evt_in)));

  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && unmapped) |=> ($stable(pin_oe) && $stable(pin_out)
                              && $stable(irq_en_o) && $stable(irq_type_o)));

  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> (bus_rdata == '0));

  a_r6_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_addr |=> (bus_rdata == '0));
endmodule

bind pinbank_regfile pinbank_chk #(.N_PINS(N_PINS), .TYPE_BITS(N_PORTS*TYPE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .evt_in(evt_in), .pin_oe(pin_oe), .pin_out(pin_out),
  .irq_en_o(irq_en_o), .irq_type_o(irq_type_o), .irq_stat_o(irq_stat_o)
);

// File: tb/pinbank_regfile_tb.sv
`timescale 1ns/1ps
module pinbank_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pin_in, pin_out, pin_oe, pin_level, evt_in, irq_en_o, irq_stat_o;
  logic [95:0] irq_type_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0]  m_cfg [4];
  logic [7:0]  m_oe  [4];
  logic [7:0]  m_out [4];
  logic [7:0]  m_ien [4];
  logic [7:0]  m_stat[4];
  logic [23:0] m_type[4];

  always #5 clk = ~clk;

  pinbank_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_level(pin_level), .evt_in(evt_in),
    .irq_en_o(irq_en_o), .irq_type_o(irq_type_o), .irq_stat_o(irq_stat_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); evt_in = e;
    @(negedge clk); evt_in = '0;
  endtask

  function automatic logic [31:0] pack8(input logic [7:0] a [4]);
    return {a[3], a[2], a[1], a[0]};
  endfunction

  task automatic check_all_regs(input string tag);
    logic [31:0] d;
    for (int p = 0; p < 4; p++) begin
      rd(12'(p*4),        d); chk({tag, " cfg"},  d, {24'h0, m_cfg[p]});
      rd(12'(16 + p*4),   d); chk({tag, " oe"},   d, {24'h0, m_oe[p]});
      rd(12'(32 + p*4),   d); chk({tag, " out"},  d, {24'h0, m_out[p]});
      rd(12'(64 + p*4),   d); chk({tag, " stat"}, d, {24'h0, m_stat[p]});
      rd(12'(80 + p*4),   d); chk({tag, " ien"},  d, {24'h0, m_ien[p]});
      rd(12'(96 + p*4),   d); chk({tag, " type"}, d, {8'h0, m_type[p]});
    end
  endtask

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pin_in = '0; evt_in = '0;
    for (int p = 0; p < 4; p++) begin
      m_cfg[p] = '0; m_oe[p] = '0; m_out[p] = '0;
      m_ien[p] = '0; m_stat[p] = '0; m_type[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports and across the whole map
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 irq_stat", irq_stat_o, 0);
    chk("R1 irq_en", irq_en_o, 0);
    chk("R1 irq_type", irq_type_o[31:0] | irq_type_o[63:32] | irq_type_o[95:64], 0);
    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 8; f++) begin
        rd(12'(f*16 + p*4), d); chk("R1 reg read", d, 0);
      end

    // R2: plain write and readback on every port and writable byte register
    for (int p = 0; p < 4; p++) begin
      logic [7:0]  pat;
      logic [23:0] tp;
      pat = 8'(p*37 + 90);       wr(12'(p*4),      {24'hC3C3C3, pat}); m_cfg[p] = pat;
      pat = 8'(p*37 + 101);      wr(12'(16 + p*4), {24'hC3C3C3, pat}); m_oe[p]  = pat;
      pat = 8'(p*59 + 13);       wr(12'(32 + p*4), {24'hC3C3C3, pat}); m_out[p] = pat;
      pat = 8'(p*71 + 7);        wr(12'(80 + p*4), {24'hC3C3C3, pat}); m_ien[p] = pat;
      tp  = 24'(p*40503 + 24'h5A0F1); wr(12'(96 + p*4), {8'hEE, tp}); m_type[p] = tp;
    end
    check_all_regs("R2");
    chk("R2 irq_en_o", irq_en_o, pack8(m_ien));
    for (int p = 0; p < 4; p++)
      chk("R2 irq_type_o", {8'h0, irq_type_o[p*24 +: 24]}, {8'h0, m_type[p]});

    // R8: driver enable gating and output value
    chk("R8 pin_out", pin_out, pack8(m_out));
    chk("R8 pin_oe", pin_oe, pack8(m_cfg) & pack8(m_oe));
    for (int k = 0; k < 16; k++) begin
      m_cfg[3] = 8'(k*17); m_oe[3] = 8'(k*23 + 1);
      wr(12'h00C, {24'h0, m_cfg[3]});
      wr(12'h01C, {24'h0, m_oe[3]});
      chk("R8 pin_oe sweep", pin_oe, pack8(m_cfg) & pack8(m_oe));
    end

    // R3: masked alias updates only selected pins
    for (int k = 0; k < 32; k++) begin
      logic [7:0] m, v;
      m = 8'(k*73 + 5); v = 8'(k*151 + 3);
      m_out[1] = (m_out[1] & ~m) | (v & m);
      wr(12'h824, {16'hBEEF, m, v});
      rd(12'h024, d); chk("R3 masked out", d, {24'h0, m_out[1]});
      chk("R3 pin_out", pin_out, pack8(m_out));
    end
    for (int k = 0; k < 16; k++) begin
      logic [7:0] m, v;
      m = 8'(k*29 + 1); v = 8'(k*97 + 11);
      m_cfg[2] = (m_cfg[2] & ~m) | (v & m);
      wr(12'h808, {16'h1234, m, v});
      m_type[0][7:0] = (m_type[0][7:0] & ~m) | (v & m);
      wr(12'h860, {16'hFFFF, m, v});
      m_oe[0] = (m_oe[0] & ~m) | (v & m);
      wr(12'h810, {16'h0, m, v});
      m_ien[3] = (m_ien[3] & ~m) | (v & m);
      wr(12'h85C, {16'h0, m, v});
    end
    check_all_regs("R3");

    // R9: unmapped addresses ignore writes and read zero
    wr(12'h001, 32'hFFFF_FFFF);
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h0A4, 32'hFFFF_FFFF);
    wr(12'h830, 32'hFFFF_FFFF);
    wr(12'h870, 32'hFFFF_FFFF);
    wr(12'h112, 32'hFFFF_FFFF);
    check_all_regs("R9");
    rd(12'h001, d); chk("R9 misaligned read", d, 0);
    rd(12'h084, d); chk("R9 bank read", d, 0);
    rd(12'h820, d); chk("R9 masked read", d, 0);
    rd(12'h830, d); chk("R9 masked input read", d, 0);

    // R10: read data follows the address one clock later
    @(negedge clk); bus_addr = 12'h00C;
    @(negedge clk); bus_addr = 12'h024;
    chk("R10 first addr", bus_rdata, {24'h0, m_cfg[3]});
    @(negedge clk);
    chk("R10 second addr", bus_rdata, {24'h0, m_out[1]});

    // R4: synchronizer latency edge by edge
    @(negedge clk); bus_addr = 12'h034; bus_we = 1'b0;
    @(negedge clk); pin_in = 32'h0000_5A00;
    @(negedge clk); chk("R4 after 1 edge", bus_rdata, 0);
    chk("R4 pin_level after 1 edge", pin_level, 0);
    @(negedge clk); chk("R4 after 2 edges", bus_rdata, 0);
    chk("R4 pin_level after 2 edges", pin_level, 32'h0000_5A00);
    @(negedge clk); chk("R4 after 3 edges", bus_rdata, 32'h5A);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] pv;
      pv = 32'(k) * 32'h9E37_79B1;
      @(negedge clk); pin_in = pv;
      repeat (3) @(negedge clk);
      for (int p = 0; p < 4; p++) begin
        rd(12'(48 + p*4), d); chk("R4 input sweep", d, {24'h0, pv[p*8 +: 8]});
      end
    end

    // R5: events set sticky status
    pulse(32'h0000_0081); m_stat[0] = 8'h81;
    pulse(32'h0300_0000); m_stat[3] = 8'h03;
    repeat (5) @(negedge clk);
    rd(12'h040, d); chk("R5 stat p0", d, 32'h81);
    rd(12'h04C, d); chk("R5 stat p3", d, 32'h03);
    chk("R5 irq_stat_o", irq_stat_o, 32'h0300_0081);
    wr(12'h844, {16'h0, 8'h0F, 8'h05}); m_stat[1] = 8'h05;
    rd(12'h044, d); chk("R5 masked status write", d, 32'h05);

    // R6: write-one-to-clear
    wr(12'h070, 32'h0000_0001); m_stat[0] = 8'h80;
    rd(12'h040, d); chk("R6 clear one bit", d, 32'h80);
    wr(12'h07C, 32'h0000_0000);
    rd(12'h04C, d); chk("R6 zeros no effect", d, 32'h03);
    rd(12'h070, d); chk("R6 clear reads zero", d, 0);
    rd(12'h07C, d); chk("R6 clear reads zero p3", d, 0);
    wr(12'h07C, 32'h0000_00FF); m_stat[3] = 8'h00;
    rd(12'h04C, d); chk("R6 clear all", d, 0);

    // R7: event beats a clear on the same bit and cycle
    pulse(32'h00FF_0000); m_stat[2] = 8'hFF;
    @(negedge clk);
    bus_addr = 12'h078; bus_we = 1'b1; bus_wdata = 32'hFF; evt_in = 32'h0008_0000;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; evt_in = '0; m_stat[2] = 8'h08;
    rd(12'h048, d); chk("R7 event wins", d, 32'h08);
    chk("R7 irq_stat_o", irq_stat_o, pack8(m_stat));
    check_all_regs("R7 final");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule